// File: doc/BRIEF.md
# Weighted Edit Distance Engine

This block computes the weighted edit distance between two sequences of 32-bit symbol codes. A host first fills two on-chip symbol stores (sequence A and sequence B) through a single write port, sets the two lengths and the three operation costs, and pulses `start`. The engine then builds the dynamic-programming table one row per A symbol and one cell per clock. It keeps only the row it is building and the row before it, in two alternating row banks. When the last cell is known it pulses `done` and presents the distance, which stays on `distance` until the next accepted start.

Cell (i, j) is the smallest of three candidates: the cell above plus the deletion cost, the cell to the left plus the insertion cost, and the diagonal cell plus the substitution cost. The substitution cost applies only when the two 32-bit symbols differ. The minimum is split across two pipeline stages. The first stage combines the above and diagonal candidates, which do not depend on the cell being finished in the same row. The second stage adds the left candidate, so the loop that carries a value from one cell to the next holds only one adder and one compare.

The controller is a state machine with six states. IDLE waits for start. ZERO produces the result of an empty sequence directly. ROW_LOAD fetches the A symbol of the next row. ROW_RUN issues one column per clock. DRAIN waits until the pipeline has written the last cell of the row. FINISH pulses done. The transitions are: IDLE to ZERO on start with a zero length; IDLE to ROW_LOAD on start with both lengths non-zero; ZERO to FINISH; ROW_LOAD to ROW_RUN; ROW_RUN to DRAIN after column M; DRAIN to ROW_LOAD when the pipeline is empty and rows remain; DRAIN to FINISH when the pipeline is empty after row N; FINISH to IDLE.

Top module: `edit_distance_engine`

## Requirements
- R1: With N = `len_a` and M = `len_b` both non-zero, `distance` equals D[N][M]. Each D[i][j] is the minimum of D[i-1][j] + `cost_del`, D[i][j-1] + `cost_ins` and D[i-1][j-1] + s. Here s is 0 when A[i-1] equals B[j-1] in all 32 bits and `cost_sub` otherwise, so symbols that differ only in bit 31 are different.
- R2: The table boundary is D[0][j] = j·`cost_ins` and D[i][0] = i·`cost_del`.
- R3: Identical sequences of equal length give a distance of 0, and with unit costs two sequences with no common symbol give max(N, M).
- R4: Either sequence may hold up to MAX_LEN symbols (default 800, so at least 750). Both stores are internal synchronous memories clocked by `clk`.
- R5: If either length is zero when start is accepted, the result is M·`cost_ins` (N = 0) or N·`cost_del` (M = 0). `done` is high in the cycle after the first clock edge that follows the accepting edge.
- R6: A `start` pulse while `busy` is high and `done` is low is ignored: the run in progress keeps its lengths, costs, timing and result.
- R7: `busy` is high from the cycle after an accepted start up to and including the `done` cycle. `done` is a single-cycle pulse.
- R8: `distance` reads 0 from the cycle after an accepted start until the result is written. After that it holds until the next accepted start.
- R9: A write with `wr_en` high stores `wr_data` at index `wr_addr` (0-based) of sequence A when `wr_sel` is 0 and of sequence B when `wr_sel` is 1. Lengths and costs are sampled at the accepting edge.
- R10: With N, M > 0 the engine issues one cell per clock in order of column, and each row takes M + 4 cycles. `done` is high in the cycle after the N·(M+4)-th edge following the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Symbol write strobe |
| wr_sel | input | 1 | 0 selects sequence A, 1 selects sequence B |
| wr_addr | input | ADDR_W (10) | Symbol index |
| wr_data | input | SYM_W (32) | Symbol code |
| len_a | input | LEN_W (10) | Length N of sequence A |
| len_b | input | LEN_W (10) | Length M of sequence B |
| cost_del | input | COST_W (8) | Deletion cost |
| cost_ins | input | COST_W (8) | Insertion cost |
| cost_sub | input | COST_W (8) | Substitution cost for differing symbols |
| start | input | 1 | Start pulse, accepted only while idle |
| busy | output | 1 | Computation in progress |
| done | output | 1 | One-cycle completion pulse |
| distance | output | DIST_W (19) | Weighted edit distance |

## Verification
The embedded properties check on every cycle that done lasts one cycle, that a start while busy does not end the run, that the result holds while idle, that an empty sequence finishes two edges after acceptance, and that issued columns advance by one each clock within a row. Whether the value is correct can only be shown by the bench. It sweeps every pair of binary-alphabet sequences up to length three under two cost sets, where the two symbols differ only in bit 31. It also runs long sequences near the length limit, identical and disjoint sequences, asymmetric costs with A and B swapped, and a start pulse injected mid-run. Each result is compared with an independent table computation, and each latency with the cycle formula.

// File: rtl/edit_pkg.sv
package edit_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ZERO,
        ST_ROW_LOAD,
        ST_ROW_RUN,
        ST_DRAIN,
        ST_FINISH
    } ed_state_t;

endpackage

// File: rtl/edit_ram.sv
module edit_ram #(
    parameter int DEPTH = 800,
    parameter int WIDTH = 32,
    localparam int AW = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data
);

    logic [WIDTH-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        if (rd_en) begin
            rd_data <= mem[rd_addr];
        end
    end

endmodule

// File: rtl/edit_ctrl.sv
module edit_ctrl
    import edit_pkg::*;
#(
    parameter int LEN_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] len_a,
    input  logic [LEN_W-1:0] len_b,
    input  logic             pipe_busy,
    output logic             busy,
    output logic             done,
    output logic             accept,
    output logic             zero_st,
    output logic             row_load,
    output logic             issue,
    output logic [LEN_W-1:0] col,
    output logic [LEN_W-1:0] row,
    output logic [LEN_W-1:0] n_len,
    output logic [LEN_W-1:0] m_len,
    output logic             first_row,
    output logic             last_row,
    output logic             sel
);

    ed_state_t        state_q, state_d;
    logic [LEN_W-1:0] row_q, col_q, n_q, m_q;
    logic             sel_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = (len_a == '0 || len_b == '0) ? ST_ZERO : ST_ROW_LOAD;
                end
            end
            ST_ZERO:     state_d = ST_FINISH;
            ST_ROW_LOAD: state_d = ST_ROW_RUN;
            ST_ROW_RUN: begin
                if (col_q == m_q) state_d = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (!pipe_busy) state_d = (row_q == n_q) ? ST_FINISH : ST_ROW_LOAD;
            end
            ST_FINISH:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            row_q   <= '0;
            col_q   <= '0;
            n_q     <= '0;
            m_q     <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                n_q   <= len_a;
                m_q   <= len_b;
                row_q <= LEN_W'(1);
                sel_q <= 1'b0;
            end
            if (state_q == ST_ROW_LOAD) begin
                col_q <= LEN_W'(1);
            end
            if (state_q == ST_ROW_RUN) begin
                col_q <= col_q + 1'b1;
            end
            if (state_q == ST_DRAIN && state_d == ST_ROW_LOAD) begin
                row_q <= row_q + 1'b1;
                sel_q <= ~sel_q;
            end
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        done      = (state_q == ST_FINISH);
        accept    = (state_q == ST_IDLE) && start;
        zero_st   = (state_q == ST_ZERO);
        row_load  = (state_q == ST_ROW_LOAD);
        issue     = (state_q == ST_ROW_RUN);
        col       = col_q;
        row       = row_q;
        n_len     = n_q;
        m_len     = m_q;
        first_row = (row_q == LEN_W'(1));
        last_row  = (row_q == n_q);
        sel       = sel_q;
    end

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> busy);

    assert_start_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: rtl/edit_cell_pipe.sv
module edit_cell_pipe #(
    parameter int SYM_W  = 32,
    parameter int COST_W = 8,
    parameter int LEN_W  = 10,
    parameter int DIST_W = 19
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [LEN_W-1:0]  in_col,
    input  logic              in_first,
    input  logic [SYM_W-1:0]  a_sym,
    input  logic [SYM_W-1:0]  b_sym,
    input  logic [DIST_W-1:0] up_val,
    input  logic [DIST_W-1:0] col0_prev,
    input  logic [DIST_W-1:0] col0_cur,
    input  logic [COST_W-1:0] c_del,
    input  logic [COST_W-1:0] c_ins,
    input  logic [COST_W-1:0] c_sub,
    output logic              out_valid,
    output logic [LEN_W-1:0]  out_col,
    output logic [DIST_W-1:0] out_val
);

    logic [DIST_W-1:0] up_last, diag, cand_up, cand_diag, part_d, part_q;
    logic [DIST_W-1:0] left_q, left_v, cand_left;
    logic              v2, first2;
    logic [LEN_W-1:0]  col2;

    // first stage: above and diagonal candidates
    always_comb begin
        diag      = in_first ? col0_prev : up_last;
        cand_up   = up_val + DIST_W'(c_del);
        cand_diag = diag + ((a_sym == b_sym) ? '0 : DIST_W'(c_sub));
        part_d    = (cand_diag < cand_up) ? cand_diag : cand_up;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v2      <= 1'b0;
            first2  <= 1'b0;
            col2    <= '0;
            part_q  <= '0;
            up_last <= '0;
            left_q  <= '0;
        end else begin
            v2 <= in_valid;
            if (in_valid) begin
                up_last <= up_val;
                part_q  <= part_d;
                col2    <= in_col;
                first2  <= in_first;
            end
            if (v2) begin
                left_q <= out_val;
            end
        end
    end

    // second stage: fold in the left neighbour
    always_comb begin
        left_v    = first2 ? col0_cur : left_q;
        cand_left = left_v + DIST_W'(c_ins);
        out_val   = (cand_left < part_q) ? cand_left : part_q;
        out_valid = v2;
        out_col   = col2;
    end

    assert_col_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_first) |-> ($past(in_valid) && in_col == $past(in_col) + 1'b1));

endmodule

// File: rtl/edit_distance_engine.sv
module edit_distance_engine #(
    parameter int SYM_W   = 32,
    parameter int MAX_LEN = 800,
    parameter int COST_W  = 8,
    localparam int LEN_W  = $clog2(MAX_LEN + 1),
    localparam int ADDR_W = $clog2(MAX_LEN),
    localparam int DIST_W = LEN_W + COST_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [SYM_W-1:0]  wr_data,
    input  logic [LEN_W-1:0]  len_a,
    input  logic [LEN_W-1:0]  len_b,
    input  logic [COST_W-1:0] cost_del,
    input  logic [COST_W-1:0] cost_ins,
    input  logic [COST_W-1:0] cost_sub,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic [DIST_W-1:0] distance
);

    logic              accept, zero_st, row_load, issue, first_row, last_row, sel;
    logic [LEN_W-1:0]  col, row, n_len, m_len, row_m1, col_m1;
    logic [COST_W-1:0] cdel_q, cins_q, csub_q;
    logic [SYM_W-1:0]  a_sym, b_sym;
    logic [DIST_W-1:0] bank_rd [2];
    logic [DIST_W-1:0] acc_q, up_init_q, up_val, col0_prev_q, col0_cur_q, dist_q;
    logic              v1, first1;
    logic [LEN_W-1:0]  col1;
    logic              cell_valid, pipe_busy;
    logic [LEN_W-1:0]  cell_col;
    logic [DIST_W-1:0] cell_val;

    assign pipe_busy = v1 || cell_valid;
    assign row_m1    = row - 1'b1;
    assign col_m1    = col - 1'b1;

    edit_ctrl #(.LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .len_a(len_a), .len_b(len_b),
        .pipe_busy(pipe_busy), .busy(busy), .done(done), .accept(accept),
        .zero_st(zero_st), .row_load(row_load), .issue(issue), .col(col), .row(row),
        .n_len(n_len), .m_len(m_len), .first_row(first_row), .last_row(last_row),
        .sel(sel)
    );

    edit_ram #(.DEPTH(MAX_LEN), .WIDTH(SYM_W)) u_seq_a (
        .clk(clk), .wr_en(wr_en && !wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(row_load), .rd_addr(row_m1[ADDR_W-1:0]), .rd_data(a_sym)
    );

    edit_ram #(.DEPTH(MAX_LEN), .WIDTH(SYM_W)) u_seq_b (
        .clk(clk), .wr_en(wr_en && wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(issue), .rd_addr(col_m1[ADDR_W-1:0]), .rd_data(b_sym)
    );

    // two row banks: the one selected by sel is written, the other is read
    for (genvar g = 0; g < 2; g++) begin : g_bank
        edit_ram #(.DEPTH(MAX_LEN + 1), .WIDTH(DIST_W)) u_row (
            .clk(clk),
            .wr_en(cell_valid && (sel == 1'(g))),
            .wr_addr(cell_col),
            .wr_data(cell_val),
            .rd_en(issue && (sel != 1'(g))),
            .rd_addr(col),
            .rd_data(bank_rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cdel_q      <= '0;
            cins_q      <= '0;
            csub_q      <= '0;
            v1          <= 1'b0;
            first1      <= 1'b0;
            col1        <= '0;
            acc_q       <= '0;
            up_init_q   <= '0;
            col0_prev_q <= '0;
            col0_cur_q  <= '0;
            dist_q      <= '0;
        end else begin
            v1 <= issue;
            if (accept) begin
                cdel_q     <= cost_del;
                cins_q     <= cost_ins;
                csub_q     <= cost_sub;
                col0_cur_q <= '0;
                dist_q     <= '0;
            end
            if (row_load) begin
                acc_q       <= DIST_W'(cins_q);
                col0_prev_q <= col0_cur_q;
                col0_cur_q  <= col0_cur_q + DIST_W'(cdel_q);
            end
            if (issue) begin
                acc_q     <= acc_q + DIST_W'(cins_q);
                up_init_q <= acc_q;
                col1      <= col;
                first1    <= (col == LEN_W'(1));
            end
            if (zero_st) begin
                dist_q <= (n_len == '0) ? DIST_W'(m_len) * DIST_W'(cins_q)
                                        : DIST_W'(n_len) * DIST_W'(cdel_q);
            end
            if (cell_valid && last_row && cell_col == m_len) begin
                dist_q <= cell_val;
            end
        end
    end

    assign up_val   = first_row ? up_init_q : bank_rd[~sel];
    assign distance = dist_q;

    edit_cell_pipe #(.SYM_W(SYM_W), .COST_W(COST_W), .LEN_W(LEN_W), .DIST_W(DIST_W)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(v1), .in_col(col1), .in_first(first1),
        .a_sym(a_sym), .b_sym(b_sym), .up_val(up_val),
        .col0_prev(col0_prev_q), .col0_cur(col0_cur_q),
        .c_del(cdel_q), .c_ins(cins_q), .c_sub(csub_q),
        .out_valid(cell_valid), .out_col(cell_col), .out_val(cell_val)
    );

    assert_dist_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(distance));

    assert_zero_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && (len_a == '0 || len_b == '0)) |=> ##1 done);

endmodule

// File: tb/test_edit_distance_engine.sv
module test_edit_distance_engine;

    localparam int MAXL = 800;
    localparam int LW   = 10;
    localparam int AW   = 10;
    localparam int CW   = 8;
    localparam int DW   = 19;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [31:0]   wr_data = '0;
    logic [LW-1:0] len_a = '0, len_b = '0;
    logic [CW-1:0] cost_del = '0, cost_ins = '0, cost_sub = '0;
    logic          start = 1'b0;
    logic          busy, done;
    logic [DW-1:0] distance;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [31:0] sa [MAXL];
    logic [31:0] sb [MAXL];

    always #5 clk = ~clk;

    edit_distance_engine i_edit_distance_engine (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .wr_data(wr_data), .len_a(len_a), .len_b(len_b), .cost_del(cost_del),
        .cost_ins(cost_ins), .cost_sub(cost_sub), .start(start), .busy(busy),
        .done(done), .distance(distance)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles >= 190000) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog R10 act=%0d exp=done", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_dist(input int n, input int m, input int dl, input int in, input int sb_c);
        int prev [MAXL+1];
        int cur  [MAXL+1];
        for (int j = 0; j <= m; j++) prev[j] = j * in;
        for (int i = 1; i <= n; i++) begin
            cur[0] = i * dl;
            for (int j = 1; j <= m; j++) begin
                int best;
                best = prev[j] + dl;
                if (cur[j-1] + in < best) best = cur[j-1] + in;
                if (prev[j-1] + ((sa[i-1] == sb[j-1]) ? 0 : sb_c) < best)
                    best = prev[j-1] + ((sa[i-1] == sb[j-1]) ? 0 : sb_c);
                cur[j] = best;
            end
            for (int j = 0; j <= m; j++) prev[j] = cur[j];
        end
        return prev[m];
    endfunction

    task automatic load(input int n, input int m);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b0; wr_addr = AW'(k); wr_data = sa[k];
        end
        for (int k = 0; k < m; k++) begin
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b1; wr_addr = AW'(k); wr_data = sb[k];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(input int n, input int m, input int dl, input int in, input int sc,
                       input string tag, input bit disturb, input int forced_exp);
        int cnt, exp_d, exp_lat;
        logic [DW-1:0] held;
        load(n, m);
        exp_d   = (forced_exp >= 0) ? forced_exp : ref_dist(n, m, dl, in, sc);
        exp_lat = (n == 0 || m == 0) ? 2 : n * (m + 4) + 1;
        @(negedge clk);
        len_a = LW'(n); len_b = LW'(m);
        cost_del = CW'(dl); cost_ins = CW'(in); cost_sub = CW'(sc);
        start = 1'b1;
        @(posedge clk);
        cnt = 1;
        #1;
        start = 1'b0;
        chk(busy == 1'b1, "R7 busy after accept", busy, 1);
        chk(distance == '0, "R8 cleared after accept", distance, 0);
        while (!done && cnt < 100000) begin
            @(posedge clk);
            cnt++;
            #1;
            if (disturb && cnt == 5) begin
                start = 1'b1; len_a = '0; cost_sub = '0;
            end else if (disturb && cnt == 6) begin
                start = 1'b0; len_a = LW'(n); cost_sub = CW'(sc);
            end
        end
        if (n == 0 || m == 0)
            chk(cnt == exp_lat, "R5 zero-length latency", cnt, exp_lat);
        else
            chk(cnt == exp_lat, "R10 latency", cnt, exp_lat);
        chk(distance == DW'(exp_d), tag, distance, exp_d);
        held = distance;
        @(posedge clk);
        #1;
        chk(done == 1'b0 && busy == 1'b0, "R7 single done", {done, busy}, 0);
        repeat (3) @(posedge clk);
        #1;
        chk(distance == held, "R8 hold", distance, held);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(busy == 1'b0 && done == 1'b0 && distance == '0, "R7 reset state", {busy, done}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // exhaustive binary sweep; the two symbols differ only in bit 31 (R1, R2)
        for (int cs = 0; cs < 2; cs++) begin
            for (int n = 0; n <= 3; n++) begin
                for (int m = 0; m <= 3; m++) begin
                    for (int pa = 0; pa < (1 << n); pa++) begin
                        for (int pb = 0; pb < (1 << m); pb++) begin
                            for (int k = 0; k < n; k++) sa[k] = pa[k] ? 32'h8000_0001 : 32'h0000_0001;
                            for (int k = 0; k < m; k++) sb[k] = pb[k] ? 32'h8000_0001 : 32'h0000_0001;
                            if (n == 0 || m == 0)
                                run(n, m, cs ? 3 : 1, cs ? 2 : 1, cs ? 5 : 1, "R5 zero-length value", 1'b0, -1);
                            else
                                run(n, m, cs ? 3 : 1, cs ? 2 : 1, cs ? 5 : 1, "R1 sweep value", 1'b0, -1);
                        end
                    end
                end
            end
        end

        // R2: boundary costs dominate when no symbol is shared and substitution is dear
        for (int k = 0; k < 3; k++) sa[k] = 32'hA000_0000 + k;
        for (int k = 0; k < 2; k++) sb[k] = 32'h0000_0100 + k;
        run(3, 2, 4, 1, 9, "R2 boundary", 1'b0, 3 * 4 + 2 * 1);

        // R3: identical sequences and disjoint sequences
        for (int k = 0; k < 40; k++) begin sa[k] = $urandom; sb[k] = sa[k]; end
        run(40, 40, 1, 1, 1, "R3 identical", 1'b0, 0);
        for (int k = 0; k < 30; k++) sa[k] = 32'h8000_0000 | 32'($urandom_range(0, 3));
        for (int k = 0; k < 20; k++) sb[k] = 32'($urandom_range(0, 3));
        run(30, 20, 1, 1, 1, "R3 disjoint", 1'b0, 30);

        // R9: asymmetric costs, then the sequences swapped between stores
        for (int k = 0; k < 4; k++) sa[k] = 32'(k + 1);
        sb[0] = 32'd2; sb[1] = 32'd4;
        run(4, 2, 1, 6, 2, "R9 A/B routing", 1'b0, -1);
        sa[0] = 32'd2; sa[1] = 32'd4;
        for (int k = 0; k < 4; k++) sb[k] = 32'(k + 1);
        run(2, 4, 1, 6, 2, "R9 swapped routing", 1'b0, -1);

        // R6: start pulse with other inputs mid-run
        for (int k = 0; k < 5; k++) begin sa[k] = 32'($urandom_range(0, 2)); sb[k] = 32'($urandom_range(0, 2)); end
        run(5, 5, 2, 3, 4, "R6 start while busy", 1'b1, -1);

        // R4: long sequences
        for (int k = 0; k < 750; k++) sa[k] = 32'($urandom_range(0, 3)) << 30;
        for (int k = 0; k < 40; k++) sb[k] = 32'($urandom_range(0, 3)) << 30;
        run(750, 40, 1, 2, 3, "R4 long A", 1'b0, -1);
        for (int k = 0; k < 40; k++) sa[k] = 32'($urandom_range(0, 3));
        for (int k = 0; k < 750; k++) sb[k] = 32'($urandom_range(0, 3));
        run(40, 750, 2, 1, 1, "R4 long B", 1'b0, -1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule